// File: doc/BRIEF.md
# Two-Wire Slave Front End for Byte-Addressed Register Space

This block sits between a two-wire serial bus and a byte-wide register and memory space addressed by sixteen bits. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It pulls the data line low through an open-drain enable. A transfer begins with a seven-bit device identifier and a direction bit. A write then carries two address bytes and data bytes. A read streams bytes from an internal address counter, which the block keeps.

On the storage side the block gives a plain strobe port. A one-cycle write strobe carries the address and the data. A one-cycle read strobe carries an address, and the storage returns its byte on the following cycle. A stop right after the two address bytes only moves the address counter. This lets a later read begin from that address. A small group of control addresses accepts writes only after two enable latches have been set in order, through writes to a dedicated lock address.

Top module: `i2cs_regport`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `DEV_ID` (default 7'h52). On a mismatch it does not acknowledge, and it leaves the data line released for the rest of the transfer.
- R2: A write-direction address byte (bit 0 = 0) is followed by the address high byte, the address low byte and data bytes. The slave acknowledges each of them. Each data byte gives one `mem_we_o` pulse carrying the counter address and that byte.
- R3: After each written byte, the low four address bits increment modulo 16 and the upper twelve bits stay the same, so sequential writes wrap within a 16-byte page.
- R4: A read-direction address byte (bit 0 = 1) makes the slave send the byte stored at the counter address, MSB first. The counter then increments across the full 16 bits. A master acknowledge fetches the next byte. A master non-acknowledge ends the read.
- R5: A stop right after the two address bytes loads the counter with that address and produces no write strobe. A later read begins at that address.
- R6: A stop releases the data line and returns the slave to standby. Until the next start, no bus activity produces an acknowledge or a strobe.
- R7: A write to addresses 16'h0020..16'h002E is acknowledged but gives no `mem_we_o` unless both enable latches are set.
- R8: A write to the lock address 16'h002F is always forwarded, and it updates the latches from its data. If bit 1 = 0, both latches clear. If bit 1 = 1 and bit 2 = 1 while the first latch is already set, the second latch sets. If bit 1 = 1 in any other case, the first latch sets and the second clears.
- R9: After reset the data line is released, no strobe is active, the counter is 16'h0000 and both latches are clear.
- R10: `mem_re_o` is a single-cycle pulse. The byte on `mem_rdata_i` in the next cycle is the one sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| mem_addr_o | output | 16 | Storage address for the current strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_re_o | output | 1 | One-cycle read strobe |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_re_o` |

## Verification
A corrupted address counter appears on the next strobe. It shows as a wrong `mem_addr_o` on a write, or as a wrong byte returned on a read, within one byte time. A stuck or misordered enable latch appears when a protected address is next written: a strobe is either missing or extra on `mem_we_o`. A wrong transfer state shows up within one bus clock, as a missing or extra acknowledge in the ninth bit slot, or as a data line held low after a stop. The bench compares every strobe against a queue of expected writes and compares every bus bit against its model of the transfer.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_cur, scl_prv, sda_cur, sda_prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_cur = scl_p[SYNC_STAGES-1];
  assign scl_prv = scl_p[SYNC_STAGES];
  assign sda_cur = sda_p[SYNC_STAGES-1];
  assign sda_prv = sda_p[SYNC_STAGES];

  assign sda_o      = sda_cur;
  assign scl_rise_o = scl_cur & ~scl_prv;
  assign scl_fall_o = ~scl_cur & scl_prv;
  // data edges while the clock stays high
  assign start_o    = scl_cur & scl_prv & sda_prv & ~sda_cur;
  assign stop_o     = scl_cur & scl_prv & ~sda_prv & sda_cur;
endmodule

// File: rtl/i2cs_wr_guard.sv
`timescale 1ns/1ps
module i2cs_wr_guard
  import i2cs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_LO   = 16'h0020,
  parameter logic [ADDR_W-1:0] CTRL_HI   = 16'h002E,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h002F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wel_bit_i,
  input  logic              rwel_bit_i,
  output logic              wr_allow_o
);
  logic wel_q, rwel_q;
  logic in_ctrl;

  assign in_ctrl    = (wr_addr_i >= CTRL_LO) && (wr_addr_i <= CTRL_HI);
  assign wr_allow_o = !in_ctrl || (wel_q && rwel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (wr_req_i && wr_addr_i == LOCK_ADDR) begin
      if (!wel_bit_i) begin
        wel_q  <= 1'b0;
        rwel_q <= 1'b0;
      end else if (rwel_bit_i && wel_q) begin
        rwel_q <= 1'b1;
      end else begin
        wel_q  <= 1'b1;
        rwel_q <= 1'b0;
      end
    end
  end

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rwel_q) |-> $past(wel_q)); // R8
  AST_RWEL_UNDER_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwel_q |-> wel_q); // R8
endmodule

// File: rtl/i2cs_regport.sv
`timescale 1ns/1ps
module i2cs_regport
  import i2cs_pkg::*;
#(
  parameter logic [6:0]        DEV_ID      = 7'h52,
  parameter int                PAGE_BITS   = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_LO     = 16'h0020,
  parameter logic [ADDR_W-1:0] CTRL_HI     = 16'h002E,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 16'h002F,
  parameter int                WEL_BIT     = 1,
  parameter int                RWEL_BIT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam logic [PAGE_BITS-1:0] PG_ONE = PAGE_BITS'(1);
  localparam logic [3:0] BITS_LAST = 4'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  state_e state_q;
  logic [3:0] cnt_q;
  logic [BYTE_W-1:0] sr_q, tx_q, rd_buf_q, hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic ack_ph_q, rw_q, re_q;
  logic byte_done, wr_fire, wr_allow;

  i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign byte_done = scl_fall && !ack_ph_q && cnt_q == BITS_LAST && !stop_det && !start_det;
  assign wr_fire   = byte_done && state_q == ST_WDAT;

  i2cs_wr_guard #(.CTRL_LO(CTRL_LO), .CTRL_HI(CTRL_HI), .LOCK_ADDR(LOCK_ADDR)) u_guard (
    .clk_i, .rst_ni,
    .wr_req_i(wr_fire), .wr_addr_i(addr_q),
    .wel_bit_i(sr_q[WEL_BIT]), .rwel_bit_i(sr_q[RWEL_BIT]),
    .wr_allow_o(wr_allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; tx_q <= '0; rd_buf_q <= '0;
      hi_q <= '0; addr_q <= '0; ack_ph_q <= 1'b0; rw_q <= 1'b0; re_q <= 1'b0;
      sda_oe_o <= 1'b0; mem_addr_o <= '0; mem_wdata_o <= '0;
      mem_we_o <= 1'b0; mem_re_o <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      mem_re_o <= 1'b0;
      re_q     <= mem_re_o;
      if (re_q) rd_buf_q <= mem_rdata_i;
      if (stop_det) begin
        state_q <= ST_IDLE; sda_oe_o <= 1'b0; ack_ph_q <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_DEV; cnt_q <= '0; sda_oe_o <= 1'b0; ack_ph_q <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (!ack_ph_q) begin
              if (scl_rise && cnt_q != BITS_LAST) begin
                sr_q  <= {sr_q[BYTE_W-2:0], sda_s};
                cnt_q <= cnt_q + 4'd1;
              end else if (byte_done) begin
                cnt_q <= '0; ack_ph_q <= 1'b1; sda_oe_o <= 1'b1;
                case (state_q)
                  ST_DEV: begin
                    if (sr_q[7:1] != DEV_ID) begin
                      state_q <= ST_IDLE; ack_ph_q <= 1'b0; sda_oe_o <= 1'b0;
                    end else begin
                      rw_q <= sr_q[0];
                      if (sr_q[0]) begin
                        mem_re_o <= 1'b1; mem_addr_o <= addr_q; addr_q <= addr_q + 1'b1;
                      end
                    end
                  end
                  ST_AHI: hi_q <= sr_q;
                  ST_ALO: addr_q <= {hi_q, sr_q};
                  default: begin
                    mem_we_o <= wr_allow; mem_addr_o <= addr_q; mem_wdata_o <= sr_q;
                    addr_q <= {addr_q[ADDR_W-1:PAGE_BITS], addr_q[PAGE_BITS-1:0] + PG_ONE};
                  end
                endcase
              end
            end else if (scl_fall) begin
              ack_ph_q <= 1'b0; sda_oe_o <= 1'b0;
              case (state_q)
                ST_DEV: begin
                  if (rw_q) begin
                    state_q <= ST_RDAT; tx_q <= rd_buf_q; sda_oe_o <= ~rd_buf_q[7];
                  end else state_q <= ST_AHI;
                end
                ST_AHI:  state_q <= ST_ALO;
                ST_ALO:  state_q <= ST_WDAT;
                default: ;
              endcase
            end
          end
          ST_RDAT: begin
            if (!ack_ph_q) begin
              if (scl_fall) begin
                if (cnt_q == BITS_LAST - 4'd1) begin
                  sda_oe_o <= 1'b0; ack_ph_q <= 1'b1; cnt_q <= '0;
                end else begin
                  cnt_q <= cnt_q + 4'd1; tx_q <= {tx_q[BYTE_W-2:0], 1'b0}; sda_oe_o <= ~tx_q[6];
                end
              end
            end else if (scl_rise) begin
              if (sda_s) state_q <= ST_IDLE;  // master declined more data
              else begin
                mem_re_o <= 1'b1; mem_addr_o <= addr_q; addr_q <= addr_q + 1'b1;
              end
            end else if (scl_fall) begin
              ack_ph_q <= 1'b0; tx_q <= rd_buf_q; sda_oe_o <= ~rd_buf_q[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R2
  AST_PAGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> addr_q[ADDR_W-1:PAGE_BITS] == $past(addr_q[ADDR_W-1:PAGE_BITS])); // R3
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state_q == ST_IDLE); // R6
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o); // R6
  AST_RE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o); // R10
endmodule

// File: tb/i2cs_regport_test.sv
`timescale 1ns/1ps
module i2cs_regport_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_a[$];
  logic [7:0]  exp_d[$];
  logic prev_re = 1'b0;

  i2cs_regport uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_fn(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // storage model: registered read, one cycle after the strobe (R10)
  always_ff @(posedge clk) if (mem_re) mem_rdata <= mem_fn(mem_addr);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of strobes against the expected write queue
  always @(negedge clk) if (rst_n && !done) begin
    if (mem_we) begin
      if (exp_a.size() == 0) chk("R7", "unexpected write addr", int'(mem_addr), -1);
      else begin
        chk("R2", "write addr", int'(mem_addr), int'(exp_a.pop_front()));
        chk("R2", "write data", int'(mem_wdata), int'(exp_d.pop_front()));
      end
    end
    if (mem_we && mem_re) chk("R2", "we and re together", 1, 0);
    if (prev_re && mem_re) chk("R10", "read strobe longer than 1", 1, 0);
    prev_re = mem_re;
  end

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(4*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = !sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = !mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic tx_chk(input logic [7:0] b, input string req, input logic exp_ack);
    logic ack;
    send_byte(b, ack);
    chk(req, "ack bit", int'(ack), int'(exp_ack));
  endtask

  task automatic addr_phase(input logic [15:0] a);
    bus_start();
    tx_chk(8'hA4, "R1", 1'b1);
    tx_chk(a[15:8], "R2", 1'b1);
    tx_chk(a[7:0], "R2", 1'b1);
  endtask

  task automatic rx_chk(input logic mack, input logic [7:0] exp, input string req);
    logic [7:0] b;
    recv_byte(mack, b);
    chk(req, "read byte", int'(b), int'(exp));
  endtask

  task automatic push(input logic [15:0] a, input logic [7:0] d);
    exp_a.push_back(a); exp_d.push_back(d);
  endtask

  task automatic q_empty(input string req);
    wq(4);
    chk(req, "pending expected writes", exp_a.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wq(5);
    chk("R9", "sda_oe after reset", int'(sda_oe), 0);
    chk("R9", "we after reset", int'(mem_we), 0);
    chk("R9", "re after reset", int'(mem_re), 0);
    rst_n = 1'b1;
    wq(10);

    // R9: counter starts at zero, current-address read
    bus_start();
    tx_chk(8'hA5, "R1", 1'b1);
    rx_chk(1'b0, mem_fn(16'h0000), "R9");
    bus_stop();

    // R2: single byte write
    addr_phase(16'h0123);
    push(16'h0123, 8'hA5);
    tx_chk(8'hA5, "R2", 1'b1);
    bus_stop();
    q_empty("R2");

    // R1: foreign identifier, further bytes ignored
    bus_start();
    tx_chk(8'hB4, "R1", 1'b0);
    tx_chk(8'h00, "R1", 1'b0);
    bus_stop();
    q_empty("R1");

    // R3: sequential write wraps in page
    addr_phase(16'h004E);
    push(16'h004E, 8'h11); push(16'h004F, 8'h22); push(16'h0040, 8'h33);
    tx_chk(8'h11, "R3", 1'b1);
    tx_chk(8'h22, "R3", 1'b1);
    tx_chk(8'h33, "R3", 1'b1);
    bus_stop();
    q_empty("R3");

    // R5: set current address, then R4 sequential read across page
    addr_phase(16'h00FE);
    bus_stop();
    q_empty("R5");
    bus_start();
    tx_chk(8'hA5, "R5", 1'b1);
    rx_chk(1'b1, mem_fn(16'h00FE), "R5");
    rx_chk(1'b1, mem_fn(16'h00FF), "R4");
    rx_chk(1'b0, mem_fn(16'h0100), "R4");
    bus_stop();
    chk("R6", "sda_oe after stop", int'(sda_oe), 0);

    // R4: random read with repeated start
    addr_phase(16'h1234);
    bus_start();
    tx_chk(8'hA5, "R4", 1'b1);
    rx_chk(1'b0, mem_fn(16'h1234), "R4");
    bus_stop();

    // R7: locked control write acked and dropped
    addr_phase(16'h0020);
    tx_chk(8'h55, "R7", 1'b1);
    bus_stop();
    q_empty("R7");
    // R8: second bit without first only sets the first latch
    addr_phase(16'h002F); push(16'h002F, 8'h06);
    tx_chk(8'h06, "R8", 1'b1);
    bus_stop();
    addr_phase(16'h0020);
    tx_chk(8'h66, "R8", 1'b1);
    bus_stop();
    q_empty("R8");
    addr_phase(16'h002F); push(16'h002F, 8'h06);
    tx_chk(8'h06, "R8", 1'b1);
    bus_stop();
    addr_phase(16'h0020); push(16'h0020, 8'h77); push(16'h0021, 8'h78);
    tx_chk(8'h77, "R7", 1'b1);
    tx_chk(8'h78, "R7", 1'b1);
    bus_stop();
    q_empty("R7");
    addr_phase(16'h002F); push(16'h002F, 8'h00);
    tx_chk(8'h00, "R8", 1'b1);
    bus_stop();
    addr_phase(16'h0021);
    tx_chk(8'h99, "R8", 1'b1);
    bus_stop();
    q_empty("R8");

    // R6: stop mid-transfer, then bus traffic without a start
    bus_start();
    tx_chk(8'hA4, "R6", 1'b1);
    tx_chk(8'h00, "R6", 1'b1);
    bus_stop();
    scl_m = 1'b0; wq(Q);
    tx_chk(8'hA4, "R6", 1'b0);
    tx_chk(8'h55, "R6", 1'b0);
    bus_stop();
    chk("R6", "sda_oe in standby", int'(sda_oe), 0);
    q_empty("R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule